// File: doc/BRIEF.md
# Command-Driven Sixteen-Line I/O Port

This block gives a small 4-bit processor sixteen general-purpose I/O lines that it drives through a two-command write interface. Each line has its own output latch. One global enable flag decides whether the latched values appear on the output pins. Clearing the flag blanks all pins but keeps every latch. Setting the flag again drives all sixteen stored values at once.

Each write carries an address and a data byte. The address must fall inside one of four 16-address windows, and a two-bit configuration input picks the window. Address bit 0 selects the command kind. The high nibble of the data byte names the line, and data bit 3 carries the new value. Each write that lands in the window records the line it named. A read that lands in the window returns the sampled input level of that line in accumulator bit 3. The other accumulator bits always read as ones.

Top module: `cmd_io_port`

## Requirements
- R1: After reset, all line latches, the global enable and the held line index are 0, so every output pin is 0. A read then reports input line 0.
- R2: An in-window write with address bit 0 = 1 stores data bit 3 into the latch of the line named by data bits 7:4. While the enable is set, that pin shows the new value from the next clock edge, and no other pin changes.
- R3: While the global enable is clear, every output pin is 0. Per-line writes still update the latches.
- R4: An in-window write with address bit 0 = 0 and data bit 3 = 1 sets the enable, and from the next edge every pin shows its latch value.
- R5: An in-window write with address bit 0 = 0 and data bit 3 = 0 clears the enable and leaves all latches unchanged. A later enable shows those values again.
- R6: Every in-window write records data bits 7:4 as the held line index, whatever its command kind. An in-window read returns 4'hF when that input line is 1 and 4'h7 when it is 0.
- R7: A 7-bit address lies in the window when address bits 6:5 equal the window select and address bit 4 is 0. This gives bases 0x00, 0x20, 0x40 and 0x60 for select values 0 to 3.
- R8: Writes outside the window change no latch, no enable and no index. A read outside the window, or with the read strobe low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_sel | input | 2 | Selects which of the four address windows the port answers in |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | I/O address; bit 0 selects the command kind |
| wdata | input | 8 | Write data: bits 7:4 name the line, bit 3 is the value |
| rdata | output | 4 | Accumulator read value: 4'hF, 4'h7 or 0 |
| line_in | input | 16 | Sampled input levels of the sixteen lines |
| line_out | output | 16 | Output pin levels, gated by the global enable |

## Verification
The bench sets lines while the outputs are disabled, toggles the enable off and on, and checks that the stored pattern comes back whole. A design that cleared the latches on disable, or wrote through to the pins while disabled, fails here. It reads after a global command to confirm that global writes also move the held index. A design that updated the index only on per-line writes would report the wrong line. It switches windows and writes to addresses that differ only in the window bits or in address bit 4. A decoder that ignored either field would let a foreign write change the pins, or would return nonzero read data.

// File: rtl/cmd_io_pkg.sv
package cmd_io_pkg;
   typedef enum logic {
      CMD_GLOBAL = 1'b0,
      CMD_LINE   = 1'b1
   } cmd_kind_e;
endpackage

// File: rtl/cmd_io_decode.sv
module cmd_io_decode
   import cmd_io_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int WIN_W  = 2,
   parameter int OFS_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIN_W-1:0]  win_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic              wr_hit,
   output logic              rd_hit,
   output cmd_kind_e         cmd
);
   localparam int GAP_W = ADDR_W - WIN_W - OFS_W;

   if (GAP_W < 1) begin : g_bad_addr
      $error("cmd_io_decode: ADDR_W must exceed WIN_W + OFS_W");
   end

   logic in_win;

   always_comb begin
      in_win = (addr[ADDR_W-1 -: WIN_W] == win_sel) &&
               (addr[ADDR_W-WIN_W-1 -: GAP_W] == '0);
      wr_hit = wr_en && in_win;
      rd_hit = rd_en && in_win;
      cmd    = addr[0] ? CMD_LINE : CMD_GLOBAL;
   end
endmodule

// File: rtl/cmd_io_lines.sv
module cmd_io_lines
   import cmd_io_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int DATA_W  = 8,
   parameter int VAL_BIT = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_hit,
   input  cmd_kind_e            cmd,
   input  logic [DATA_W-1:0]    wdata,
   output logic [(1<<IDX_W)-1:0] line_out,
   output logic [IDX_W-1:0]     idx_q,
   output logic                 en_q
);
   localparam int NUM_LINES = 1 << IDX_W;

   if (DATA_W < IDX_W + VAL_BIT + 1) begin : g_bad_data
      $error("cmd_io_lines: index field overlaps value bit");
   end

   logic [IDX_W-1:0]     idx_w;
   logic [NUM_LINES-1:0] lat;

   assign idx_w = wdata[DATA_W-1 -: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         en_q  <= 1'b0;
      end else if (wr_hit) begin
         idx_q <= idx_w;
         if (cmd == CMD_GLOBAL) en_q <= wdata[VAL_BIT];
      end
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 1'b0;
         else if (wr_hit && cmd == CMD_LINE && idx_w == IDX_W'(g))
            q <= wdata[VAL_BIT];
      end
      assign lat[g]      = q;
      assign line_out[g] = en_q & q;
   end

   // R6: every accepted write records its line index
   assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> idx_q == $past(idx_w));

   // R5: a global command leaves every latch as it was
   assert_latch_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && cmd == CMD_GLOBAL) |=> lat == $past(lat));
endmodule

// File: rtl/cmd_io_readmux.sv
module cmd_io_readmux #(
   parameter int IDX_W = 4,
   parameter int ACC_W = 4
) (
   input  logic [(1<<IDX_W)-1:0] line_in,
   input  logic [IDX_W-1:0]      idx,
   input  logic                  rd_hit,
   output logic [ACC_W-1:0]      rdata
);
   if (ACC_W < 2) begin : g_bad_acc
      $error("cmd_io_readmux: ACC_W must be at least 2");
   end

   always_comb begin
      if (rd_hit) rdata = {line_in[idx], {(ACC_W-1){1'b1}}};
      else        rdata = '0;
   end

   always_comb begin
      assert_rd_code_R6: assert (rdata == '0 || rdata[ACC_W-2:0] == '1);
   end
endmodule

// File: rtl/cmd_io_port.sv
module cmd_io_port
   import cmd_io_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int DATA_W  = 8,
   parameter int VAL_BIT = 3,
   parameter int ACC_W   = 4,
   parameter int WIN_W   = 2,
   parameter int OFS_W   = 4,
   parameter int ADDR_W  = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIN_W-1:0]       win_sel,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [ACC_W-1:0]       rdata,
   input  logic [(1<<IDX_W)-1:0]  line_in,
   output logic [(1<<IDX_W)-1:0]  line_out
);
   logic             wr_hit, rd_hit, en_q;
   logic [IDX_W-1:0] idx_q;
   cmd_kind_e        cmd;

   cmd_io_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .OFS_W(OFS_W)) u_dec (
      .addr(addr), .win_sel(win_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_hit(wr_hit), .rd_hit(rd_hit), .cmd(cmd));

   cmd_io_lines #(.IDX_W(IDX_W), .DATA_W(DATA_W), .VAL_BIT(VAL_BIT)) u_lines (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .cmd(cmd), .wdata(wdata),
      .line_out(line_out), .idx_q(idx_q), .en_q(en_q));

   cmd_io_readmux #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_rd (
      .line_in(line_in), .idx(idx_q), .rd_hit(rd_hit), .rdata(rdata));

   // R8: without an accepted write the pins hold
   assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(line_out));

   // R2: a per-line write while enabled shows on its pin
   assert_line_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr[0] && en_q) |=>
         line_out[$past(wdata[DATA_W-1 -: IDX_W])] == $past(wdata[VAL_BIT]));

   // R5: a global disable blanks every pin
   assert_disable_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !addr[0] && !wdata[VAL_BIT]) |=> line_out == '0);

   // R3: per-line writes while disabled keep the pins dark
   assert_dark_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr[0] && !en_q) |=> line_out == '0);
endmodule

// File: tb/cmd_io_port_tb.sv
`timescale 1ns/1ps
module cmd_io_port_tb;
   typedef struct {
      logic [15:0] out;
      logic [3:0]  rd;
      string       req;
   } exp_t;

   logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
   logic [1:0]  win_sel = 0;
   logic [6:0]  addr = 0;
   logic [7:0]  wdata = 0;
   logic [15:0] line_in = 0;
   logic [3:0]  rdata;
   logic [15:0] line_out;

   int errs = 0, checks = 0;
   bit done = 0;
   exp_t q[$];

   logic [15:0] m_lat = 0;
   logic        m_en = 0;
   logic [3:0]  m_idx = 0;

   always #4 clk = ~clk;

   cmd_io_port u_dut (.clk(clk), .rst_n(rst_n), .win_sel(win_sel), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .line_in(line_in), .line_out(line_out));

   function automatic bit hit(logic [6:0] a);
      return a[6:5] == win_sel && !a[4];
   endfunction

   function automatic logic [15:0] m_out();
      return m_en ? m_lat : 16'h0;
   endfunction

   task automatic push(logic [3:0] rd, string r);
      exp_t e;
      e.out = m_out(); e.rd = rd; e.req = r;
      q.push_back(e);
   endtask

   task automatic wr(logic [6:0] a, logic [7:0] d, string r);
      @(negedge clk); #2;
      addr = a; wdata = d; wr_en = 1;
      @(posedge clk); #1;
      wr_en = 0;
      if (hit(a)) begin
         m_idx = d[7:4];
         if (a[0]) m_lat[d[7:4]] = d[3];
         else      m_en = d[3];
      end
      push(4'h0, r);
   endtask

   task automatic rd(logic [6:0] a, logic [15:0] lin, string r);
      @(negedge clk); #2;
      addr = a; line_in = lin; rd_en = 1;
      push(hit(a) ? (lin[m_idx] ? 4'hF : 4'h7) : 4'h0, r);
      @(negedge clk); #1;
      rd_en = 0;
   endtask

   // monitor: pops and compares at each falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (line_out !== e.out || rdata !== e.rd) begin
               errs++;
               $display("FAIL %s: line_out=%h rdata=%h expected line_out=%h rdata=%h",
                        e.req, line_out, rdata, e.out, e.rd);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #2 rst_n = 1;
      push(4'h0, "R1");
      rd(7'h00, 16'h0001, "R1");            // index 0 after reset
      wr(7'h01, 8'h38, "R3");               // set line 3 while disabled
      wr(7'h03, 8'hA8, "R3");               // set line 10 (odd offset)
      wr(7'h00, 8'h08, "R4");               // enable
      wr(7'h01, 8'h58, "R2");               // set line 5 while enabled
      wr(7'h05, 8'h30, "R2");               // clear line 3
      wr(7'h00, 8'hC0, "R5");               // disable, index -> 12
      rd(7'h02, 16'h1000, "R6");            // index from global command
      rd(7'h02, 16'hEFFF, "R6");
      wr(7'h00, 8'h18, "R5");               // re-enable, pattern returns
      for (int i = 0; i < 16; i++) begin
         wr(7'h01, {i[3:0], 4'h8}, "R2");
         rd(7'h0E, 16'h1 << i, "R6");
         rd(7'h0E, ~(16'h1 << i), "R6");
      end
      wr(7'h00, 8'h00, "R5");
      wr(7'h00, 8'h08, "R5");
      win_sel = 2'd2;
      wr(7'h01, 8'h20, "R8");               // window 0 now foreign
      rd(7'h01, 16'hFFFF, "R8");
      wr(7'h41, 8'h20, "R7");               // window 2 accepted
      rd(7'h4F, 16'h0004, "R7");
      wr(7'h51, 8'h40, "R8");               // address bit 4 set
      wr(7'h50, 8'h00, "R8");
      rd(7'h51, 16'hFFFF, "R8");
      rd(7'h61, 16'hFFFF, "R8");
      win_sel = 2'd3;
      wr(7'h60, 8'h70, "R7");               // disable via window 3
      wr(7'h6F, 8'h08, "R7");               // set line 0, stays dark
      wr(7'h62, 8'h08, "R4");
      @(negedge clk); #2 addr = 7'h60; rd_en = 0; line_in = 16'hFFFF;
      push(4'h0, "R8");                     // strobe low reads 0
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule